// File: doc/BRIEF.md
# Byte-Wide Double-Buffered DAC Front End

This block is the digital side of a 14-bit current-steering converter that hangs off an 8-bit processor bus. The processor drives an active-low select, an active-low write strobe, a two-bit address and a byte of data. The block brings these into its own clock domain and holds the word in two staging registers: six bits for the upper part and eight bits for the lower part. On request it moves them together into the converter register. Because staging is separate from the converter register, several converters can be primed one after another and then updated together. A pass-through address instead loads the whole converter register from one byte, so zero or full scale takes a single write.

The converter register drives the switch array directly. Its three top bits are decoded into seven equal-weight segment enables in thermometer form. Its eleven low bits drive the binary ladder switches one for one. A sticky flag records a transfer that was made while only one of the two staging registers held fresh data.

Top module: `bytewide_dac_front`

## Requirements
- R1: After reset all registers are zero: `seg_en` is 7'b0, `ladder_sw` is 11'b0 and `half_xfer` is 0.
- R2: A write is accepted only if `cs_n` is low when `wr_n` rises. Strobes made with `cs_n` high leave every output and register unchanged.
- R3: Address 2'b01 loads the upper staging register from `bus[5:0]`, and `bus[7:6]` are dropped. Address 2'b10 loads the lower staging register from `bus[7:0]`. Neither write changes `seg_en` or `ladder_sw`.
- R4: Address 2'b11 copies {upper, lower} into the 14-bit converter register. The bus value on that write has no effect.
- R5: Address 2'b00 is pass-through. Upper takes `bus[5:0]`, lower takes `bus`, and the converter register takes {`bus[5:0]`, `bus`}. A byte of 8'h00 gives zero scale and 8'hFF gives full scale.
- R6: For k = converter bits [13:11], `seg_en[k-1:0]` are high and the other lines are low. `seg_en[0]` is the first line to turn on.
- R7: `ladder_sw[i]` equals converter bit i for i = 0..10.
- R8: A write commits once, on the rising edge of `wr_n`. It uses the address and data present before that edge. Holding `wr_n` low commits nothing, and bus changes made at or after the rise have no effect.
- R9: `half_xfer` rises on a 2'b11 transfer when exactly one staging register has been written since the previous transfer or pass-through. It then stays high until reset. A transfer after both writes, or after neither, leaves it unchanged.

Both staging registers have the write tracking cleared by a transfer (R9) and by a pass-through write (R5).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low select, asynchronous |
| wr_n | input | 1 | Active-low write strobe, asynchronous |
| addr | input | 2 | Operation select |
| bus | input | 8 | Data byte |
| seg_en | output | 7 | Thermometer enables for the upper three bits |
| ladder_sw | output | 11 | Binary ladder switch drives |
| half_xfer | output | 1 | Sticky flag for a transfer with only one byte refreshed |

## Verification
The hardest condition to create is the half-refreshed transfer. The flag must stay low after transfers that follow both byte writes, and after a transfer that follows no write at all. It must then rise only once a single upper-byte write is followed by a transfer. The stimulus therefore runs a full two-byte sequence first, then an empty transfer, and only then the single-byte case. A full sequence follows to show that the flag holds. A second hard case is data that changes in the same cycle the strobe rises: the bench inverts the address and bus at that moment, so any use of post-edge values shows up as a wrong output.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
  typedef enum logic [1:0] {
    OP_PASS = 2'b00,
    OP_HI   = 2'b01,
    OP_LO   = 2'b10,
    OP_XFER = 2'b11
  } bus_op_e;
endpackage

// File: rtl/dacfe_sync.sv
module dacfe_sync #(
  parameter int          W       = 12,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] stage1_q, stage2_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        stage1_q[i] <= RST_VAL[i];
        stage2_q[i] <= RST_VAL[i];
      end else begin
        stage1_q[i] <= d_async[i];
        stage2_q[i] <= stage1_q[i];
      end
    end
  end

  assign d_sync = stage2_q;
endmodule

// File: rtl/dacfe_wrdec.sv
module dacfe_wrdec
  import dacfe_pkg::*;
#(
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n_s,
  input  logic             wr_n_s,
  input  logic [1:0]       addr_s,
  input  logic [BUS_W-1:0] bus_s,
  output logic             commit,
  output bus_op_e          op,
  output logic [BUS_W-1:0] data
);
  logic             prev_cs_n, prev_wr_n;
  logic [1:0]       prev_addr;
  logic [BUS_W-1:0] prev_bus;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_cs_n <= 1'b1;
      prev_wr_n <= 1'b1;
      prev_addr <= '0;
      prev_bus  <= '0;
    end else begin
      prev_cs_n <= cs_n_s;
      prev_wr_n <= wr_n_s;
      prev_addr <= addr_s;
      prev_bus  <= bus_s;
    end
  end

  assign commit = !prev_wr_n && wr_n_s && !prev_cs_n;
  assign op     = bus_op_e'(prev_addr);
  assign data   = prev_bus;

  AST_SINGLE_COMMIT: assert property (@(posedge clk) disable iff (rst)
    commit |=> !commit); // R8
endmodule

// File: rtl/dacfe_regs.sv
module dacfe_regs
  import dacfe_pkg::*;
#(
  parameter int HI_W  = 6,
  parameter int LO_W  = 8,
  localparam int DAC_W = HI_W + LO_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             commit,
  input  bus_op_e          op,
  input  logic [LO_W-1:0]  data,
  output logic [DAC_W-1:0] dac_q,
  output logic             half_xfer
);
  logic [HI_W-1:0] hi_q;
  logic [LO_W-1:0] lo_q;
  logic            hi_seen, lo_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q      <= '0;
      lo_q      <= '0;
      dac_q     <= '0;
      hi_seen   <= 1'b0;
      lo_seen   <= 1'b0;
      half_xfer <= 1'b0;
    end else if (commit) begin
      unique case (op)
        OP_HI: begin
          hi_q    <= data[HI_W-1:0];
          hi_seen <= 1'b1;
        end
        OP_LO: begin
          lo_q    <= data;
          lo_seen <= 1'b1;
        end
        OP_XFER: begin
          dac_q   <= {hi_q, lo_q};
          hi_seen <= 1'b0;
          lo_seen <= 1'b0;
          if (hi_seen ^ lo_seen) half_xfer <= 1'b1;
        end
        default: begin
          hi_q    <= data[HI_W-1:0];
          lo_q    <= data;
          dac_q   <= {data[HI_W-1:0], data};
          hi_seen <= 1'b0;
          lo_seen <= 1'b0;
        end
      endcase
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(dac_q)); // R2
  AST_XFER_COPY: assert property (@(posedge clk) disable iff (rst)
    (commit && op == OP_XFER) |=> dac_q == $past({hi_q, lo_q})); // R4
  AST_PASS_LOAD: assert property (@(posedge clk) disable iff (rst)
    (commit && op == OP_PASS) |=> dac_q == $past({data[HI_W-1:0], data})); // R5
  AST_STAGE_NO_DAC: assert property (@(posedge clk) disable iff (rst)
    (commit && (op == OP_HI || op == OP_LO)) |=> $stable(dac_q)); // R3
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    half_xfer |=> half_xfer); // R9
endmodule

// File: rtl/dacfe_segdec.sv
module dacfe_segdec #(
  parameter int DAC_W    = 14,
  parameter int SEG_BITS = 3,
  localparam int SEG_N = (1 << SEG_BITS) - 1,
  localparam int LAD_W = DAC_W - SEG_BITS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DAC_W-1:0] dac,
  output logic [SEG_N-1:0] seg_q,
  output logic [LAD_W-1:0] ladder_q
);
  logic [SEG_BITS-1:0] seg_val;
  logic [SEG_N-1:0]    seg_d;

  assign seg_val = dac[DAC_W-1:LAD_W];

  for (genvar i = 0; i < SEG_N; i++) begin : g_seg
    assign seg_d[i] = (32'(seg_val) > i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_q    <= '0;
      ladder_q <= '0;
    end else begin
      seg_q    <= seg_d;
      ladder_q <= dac[LAD_W-1:0];
    end
  end

  AST_SEG_COUNT: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $countones(seg_q) == int'($past(seg_val))); // R6
endmodule

// File: rtl/bytewide_dac_front.sv
module bytewide_dac_front
  import dacfe_pkg::*;
#(
  parameter int HI_W     = 6,
  parameter int BUS_W    = 8,
  parameter int SEG_BITS = 3,
  localparam int DAC_W = HI_W + BUS_W,
  localparam int SEG_N = (1 << SEG_BITS) - 1,
  localparam int LAD_W = DAC_W - SEG_BITS,
  localparam int SYN_W = BUS_W + 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic             wr_n,
  input  logic [1:0]       addr,
  input  logic [BUS_W-1:0] bus,
  output logic [SEG_N-1:0] seg_en,
  output logic [LAD_W-1:0] ladder_sw,
  output logic             half_xfer
);
  localparam logic [SYN_W-1:0] SYN_RST = {2'b11, {(SYN_W-2){1'b0}}};

  logic [SYN_W-1:0] syn_in, syn_out;
  logic             commit;
  bus_op_e          op;
  logic [BUS_W-1:0] data;
  logic [DAC_W-1:0] dac_q;

  assign syn_in = {cs_n, wr_n, addr, bus};

  dacfe_sync #(.W(SYN_W), .RST_VAL(SYN_RST)) i_sync (
    .clk(clk), .rst(rst), .d_async(syn_in), .d_sync(syn_out)
  );

  dacfe_wrdec #(.BUS_W(BUS_W)) i_wrdec (
    .clk(clk), .rst(rst),
    .cs_n_s(syn_out[SYN_W-1]), .wr_n_s(syn_out[SYN_W-2]),
    .addr_s(syn_out[BUS_W+1:BUS_W]), .bus_s(syn_out[BUS_W-1:0]),
    .commit(commit), .op(op), .data(data)
  );

  dacfe_regs #(.HI_W(HI_W), .LO_W(BUS_W)) i_regs (
    .clk(clk), .rst(rst), .commit(commit), .op(op), .data(data),
    .dac_q(dac_q), .half_xfer(half_xfer)
  );

  dacfe_segdec #(.DAC_W(DAC_W), .SEG_BITS(SEG_BITS)) i_segdec (
    .clk(clk), .rst(rst), .dac(dac_q), .seg_q(seg_en), .ladder_q(ladder_sw)
  );
endmodule

// File: tb/test_bytewide_dac_front.sv
`timescale 1ns/1ps
module test_bytewide_dac_front;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1, wr_n = 1'b1;
  logic [1:0]  addr = 2'b00;
  logic [7:0]  bus = 8'h00;
  logic [6:0]  seg_en;
  logic [10:0] ladder_sw;
  logic        half_xfer;

  int n_cmp = 0, n_bad = 0;
  logic [5:0]  m_hi = '0;
  logic [7:0]  m_lo = '0;
  logic [13:0] m_dac = '0;
  logic        m_hs = 0, m_ls = 0, m_flag = 0;

  always #2.5 clk = ~clk;

  bytewide_dac_front i_bytewide_dac_front (
    .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .addr(addr), .bus(bus),
    .seg_en(seg_en), .ladder_sw(ladder_sw), .half_xfer(half_xfer)
  );

  task automatic check(input string req);
    logic [6:0] e_seg;
    e_seg = 7'((8'd1 << m_dac[13:11]) - 8'd1);
    n_cmp++;
    if (seg_en !== e_seg || ladder_sw !== m_dac[10:0] || half_xfer !== m_flag) begin
      n_bad++;
      $display("FAIL %s: seg=%b ladder=%h flag=%b expected seg=%b ladder=%h flag=%b",
               req, seg_en, ladder_sw, half_xfer, e_seg, m_dac[10:0], m_flag);
    end
  endtask

  task automatic model(input logic [1:0] a, input logic [7:0] d);
    case (a)
      2'b01: begin m_hi = d[5:0]; m_hs = 1; end
      2'b10: begin m_lo = d; m_ls = 1; end
      2'b11: begin
        m_dac = {m_hi, m_lo};
        if (m_hs ^ m_ls) m_flag = 1;
        m_hs = 0; m_ls = 0;
      end
      default: begin
        m_hi = d[5:0]; m_lo = d; m_dac = {d[5:0], d};
        m_hs = 0; m_ls = 0;
      end
    endcase
  endtask

  // Bus and address flip in the same cycle the strobe rises (R8).
  task automatic bus_write(input logic cs_lvl, input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cs_n = cs_lvl; addr = a; bus = d; wr_n = 1'b0;
    repeat (3) @(negedge clk);
    wr_n = 1'b1; bus = ~d; addr = ~a;
    repeat (8) @(negedge clk);
    cs_n = 1'b1;
    if (!cs_lvl) model(a, d);
  endtask

  task automatic t_reset;
    check("R1 reset state");
  endtask

  task automatic t_staged;
    bus_write(0, 2'b01, 8'hEA);   // upper = 6'h2A, bits 7:6 dropped
    check("R3 upper write leaves output");
    bus_write(0, 2'b10, 8'h5C);
    check("R3 lower write leaves output");
    bus_write(0, 2'b11, 8'hFF);   // bus ignored
    check("R4 transfer copies staged word");
    check("R9 flag low after full sequence");
  endtask

  task automatic t_pass;
    bus_write(0, 2'b00, 8'hFF);
    check("R5 pass-through full scale");
    bus_write(0, 2'b00, 8'h00);
    check("R5 pass-through zero scale");
  endtask

  task automatic t_cs_off;
    bus_write(1, 2'b00, 8'hFF);
    check("R2 write without select ignored");
    bus_write(1, 2'b01, 8'h3F);
    bus_write(0, 2'b11, 8'h00);   // reveals staging untouched by unselected write
    check("R2 unselected staging write ignored");
  endtask

  task automatic t_held;
    @(negedge clk);
    cs_n = 0; addr = 2'b00; bus = 8'hA5; wr_n = 0;
    repeat (12) @(negedge clk);
    check("R8 no commit while strobe low");
    wr_n = 1; bus = 8'h00; addr = 2'b01;
    repeat (8) @(negedge clk);
    cs_n = 1;
    model(2'b00, 8'hA5);
    check("R8 commit at strobe rise with pre-edge data");
  endtask

  task automatic t_sweep;
    for (int k = 0; k < 8; k++) begin
      bus_write(0, 2'b00, 8'((k << 3) | 3'b101) ^ 8'h80);
      check($sformatf("R6 R7 segment value %0d", k));
    end
  endtask

  task automatic t_flag;
    bus_write(0, 2'b11, 8'h12);   // neither staged
    check("R9 empty transfer keeps flag low");
    bus_write(0, 2'b01, 8'h07);
    bus_write(0, 2'b11, 8'h00);
    check("R9 half transfer raises flag");
    bus_write(0, 2'b01, 8'h11);
    bus_write(0, 2'b10, 8'h22);
    bus_write(0, 2'b11, 8'h00);
    check("R9 flag sticky after full transfer");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    t_reset();
    t_staged();
    t_pass();
    t_cs_off();
    t_held();
    t_sweep();
    t_flag();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule